// File: doc/BRIEF.md
# Crosspoint Switch Control Store

This block holds the on/off state of a 12-row by 8-column grid of crosspoint switches and presents it as a 96-bit enable vector. One cell is picked by a 4-bit row code and a 3-bit column code. While the strobe input is high, the picked cell takes the value of the data input and keeps following it. When the strobe drops, the cell keeps the last value it took. Every other cell keeps its state. A clear input turns every switch off.

All control inputs are treated as asynchronous to the system clock. They pass through a two-stage synchronizer before the decode and the cell registers use them. The enable vector is a register output, so it moves only on clock edges. The enable bit for a cell sits at index `column * 12 + row`. Any number of cells may be on at once, so one column can join several rows.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: While `rst` is high, and on the first edge after it is released, `sw_en` is all zero.
- R2: Holding `stb_in` high with `data_in` = 1 sets bit `col_code*12 + row` of `sw_en`. Holding it high with `data_in` = 0 clears that bit.
- R3: Row codes 0..5 select rows 0..5. Row codes 8..13 select rows 6..11.
- R4: Row codes 6, 7, 14 and 15 select no cell. A strobe with any of these codes leaves all of `sw_en` unchanged.
- R5: While `stb_in` stays high, the selected bit follows each change of `data_in`.
- R6: After `stb_in` falls, the selected bit keeps the value `data_in` had in the last cycle the strobe was high. Later changes of `data_in` while `stb_in` is low have no effect.
- R7: A write changes at most one bit of `sw_en`. Bits set earlier stay set, so several bits can be on together.
- R8: `clr_in` high clears every bit of `sw_en`. It takes priority over a strobe that is high at the same time.
- R9: A change on any control input shows on `sw_en` on the third rising clock edge after it: two synchronizer stages, then the cell register.
- R10: Writing 0 to a cell that is on turns only that cell off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| clr_in | input | 1 | Asynchronous request to turn every switch off, active high |
| stb_in | input | 1 | Asynchronous write strobe, active high |
| data_in | input | 1 | Value for the selected cell (1 = on) |
| row_code | input | 4 | Row code; 6, 7, 14 and 15 select nothing |
| col_code | input | 3 | Column select 0..7 |
| sw_en | output | 96 | Switch enables, bit = column*12 + row |

## Verification
The assertions assume that the row and column codes stay constant for the whole time the strobe is high. They also assume that each control input is held for at least one clock, so the synchronizer passes every level on and the decode never sees a stray address for one cycle. The stimulus sets the address and data on the falling clock edge in the same cycle it raises the strobe. It holds them for several cycles, and it changes the address only while the strobe is low. Data toggles only in the tests that exercise the follow and ignore behaviour.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    parameter int ROWS    = 12;
    parameter int COLS    = 8;
    parameter int ROW_CW  = 4;
    parameter int COL_CW  = 3;
    parameter int SYNC_N  = 2;
    localparam int CELLS  = ROWS * COLS;
    localparam int ROW_IW = $clog2(ROWS);

    // control bundle carried through the synchronizer
    typedef struct packed {
        logic              clr;
        logic              stb;
        logic              din;
        logic [ROW_CW-1:0] row;
        logic [COL_CW-1:0] col;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef struct packed {
        logic              ok;
        logic [ROW_IW-1:0] idx;
    } row_t;

    // codes x110 and x111 fall in the gaps; upper bank is offset by six
    function automatic row_t map_row(input logic [ROW_CW-1:0] code);
        row_t r;
        r.ok  = (code[2:1] != 2'b11);
        r.idx = code[3] ? ROW_IW'(code[2:0]) + ROW_IW'(6) : ROW_IW'(code[2:0]);
        return r;
    endfunction

endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/xpt_decode.sv
module xpt_decode
    import xpt_pkg::*;
#(
    parameter int NR = ROWS,
    parameter int NC = COLS
) (
    input  logic [ROW_CW-1:0] row,
    input  logic [COL_CW-1:0] col,
    output logic [NR*NC-1:0]  sel
);
    row_t rm;
    assign rm = map_row(row);

    for (genvar c = 0; c < NC; c++) begin : g_col
        for (genvar r = 0; r < NR; r++) begin : g_row
            assign sel[c*NR + r] = rm.ok && (col == COL_CW'(c)) && (rm.idx == ROW_IW'(r));
        end
    end

    // R2
    always_comb sel_onehot_chk: assert ($onehot0(sel));
endmodule

// File: rtl/xpt_store.sv
module xpt_store #(
    parameter int N = 96
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         wr,
    input  logic         din,
    input  logic [N-1:0] sel,
    output logic [N-1:0] cells
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst || clr)       cells[i] <= 1'b0;
            else if (wr && sel[i]) cells[i] <= din;
        end
    end

    // strobe fall detector on the synchronized strobe
    logic wr_d;
    always_ff @(posedge clk) begin
        if (rst) wr_d <= 1'b0;
        else     wr_d <= wr;
    end
    logic wr_fall;
    assign wr_fall = wr_d && !wr;

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cells == '0));

    // R4
    gap_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && wr && (sel == '0)) |=> $stable(cells));

    // R7
    one_cell_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ($countones(cells ^ $past(cells)) <= 1));

    // R5
    follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && wr && (sel != '0)) |=> (((cells & $past(sel)) != '0) == $past(din)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_fall && !clr) |=> $stable(cells));
endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem
    import xpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_in,
    input  logic              stb_in,
    input  logic              data_in,
    input  logic [ROW_CW-1:0] row_code,
    input  logic [COL_CW-1:0] col_code,
    output logic [CELLS-1:0]  sw_en
);
    ctl_t raw, syn;
    logic [CTL_W-1:0] syn_v;
    logic [CELLS-1:0] sel;

    always_comb begin
        raw.clr = clr_in;
        raw.stb = stb_in;
        raw.din = data_in;
        raw.row = row_code;
        raw.col = col_code;
    end

    xpt_sync #(.W(CTL_W), .STAGES(SYNC_N)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn_v)
    );
    assign syn = ctl_t'(syn_v);

    xpt_decode #(.NR(ROWS), .NC(COLS)) dec_i (
        .row (syn.row),
        .col (syn.col),
        .sel (sel)
    );

    xpt_store #(.N(CELLS)) store_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (syn.clr),
        .wr    (syn.stb),
        .din   (syn.din),
        .sel   (sel),
        .cells (sw_en)
    );

    // R1
    reset_chk: assert property (@(posedge clk) rst |=> (sw_en == '0));
endmodule

// File: tb/xpt_ctrl_mem_tb_top.sv
module xpt_ctrl_mem_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_in = 1'b0, stb_in = 1'b0, data_in = 1'b0;
    logic [3:0]  row_code = '0;
    logic [2:0]  col_code = '0;
    logic [95:0] sw_en;

    always #4 clk = ~clk;  // 125 MHz

    xpt_ctrl_mem dut_i (
        .clk(clk), .rst(rst), .clr_in(clr_in), .stb_in(stb_in),
        .data_in(data_in), .row_code(row_code), .col_code(col_code),
        .sw_en(sw_en)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [95:0] model = '0;
    logic [95:0] exp_q[$];
    string       tag_q[$];
    event        chk_ev;
    bit          done = 0;

    function automatic bit code_ok(input logic [3:0] rc);
        return !(rc == 6 || rc == 7 || rc == 14 || rc == 15);
    endfunction

    function automatic int bit_of(input logic [3:0] rc, input logic [2:0] cc);
        int r = (rc < 6) ? int'(rc) : int'(rc) - 2;
        return int'(cc) * 12 + r;
    endfunction

    task automatic push(input logic [95:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        -> chk_ev;
    endtask

    // monitor: pops expected items and compares with the output
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (exp_q.size() > 0) begin
                logic [95:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (sw_en !== e) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", t, sw_en, e);
                end
            end
        end
    end

    task automatic write_cell(input logic [3:0] rc, input logic [2:0] cc, input logic v);
        @(negedge clk);
        row_code = rc; col_code = cc; data_in = v; stb_in = 1'b1;
        repeat (4) @(negedge clk);
        if (code_ok(rc)) model[bit_of(rc, cc)] = v;
        push(model, code_ok(rc) ? "R2 R3 write" : "R4 gap code ignored");
        stb_in = 1'b0;
        repeat (4) @(negedge clk);
        push(model, "R6 R7 value held after strobe fall");
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        push('0, "R1 reset state");
        #2;
        rst = 1'b0;

        // R2 R3 R4 R7: every row code, column varies
        for (int k = 0; k < 16; k++) write_cell(4'(k), 3'(k % 8), 1'b1);
        write_cell(4'd13, 3'd7, 1'b1);   // R3 top row, last column -> bit 95
        write_cell(4'd8, 3'd0, 1'b1);    // R3 first upper-bank code -> bit 6

        // R10: turn one cell off
        write_cell(4'd3, 3'd3, 1'b0);

        // R5: follow while strobe high
        @(negedge clk);
        row_code = 4'd9; col_code = 3'd5; data_in = 1'b1; stb_in = 1'b1;
        repeat (4) @(negedge clk);
        model[bit_of(4'd9, 3'd5)] = 1'b1;
        push(model, "R5 follow high");
        data_in = 1'b0;
        repeat (4) @(negedge clk);
        model[bit_of(4'd9, 3'd5)] = 1'b0;
        push(model, "R5 follow low");
        data_in = 1'b1;
        repeat (4) @(negedge clk);
        model[bit_of(4'd9, 3'd5)] = 1'b1;
        push(model, "R5 follow high again");

        // R6: drop strobe, then toggle data: no effect
        stb_in = 1'b0;
        repeat (4) @(negedge clk);
        data_in = 1'b0;
        repeat (4) @(negedge clk);
        push(model, "R6 data ignored while strobe low");

        // R9: latency of three rising edges
        @(negedge clk);
        row_code = 4'd2; col_code = 3'd6; data_in = 1'b1; stb_in = 1'b1;
        repeat (2) @(negedge clk);
        push(model, "R9 unchanged after two edges");
        @(negedge clk);
        model[bit_of(4'd2, 3'd6)] = 1'b1;
        push(model, "R9 changed on third edge");
        stb_in = 1'b0;
        repeat (4) @(negedge clk);

        // R8: clear wins over a strobe high at the same time
        @(negedge clk);
        row_code = 4'd0; col_code = 3'd7; data_in = 1'b1; stb_in = 1'b1; clr_in = 1'b1;
        repeat (4) @(negedge clk);
        model = '0;
        push(model, "R8 clear with strobe high");
        stb_in = 1'b0;
        repeat (3) @(negedge clk);
        clr_in = 1'b0;
        repeat (4) @(negedge clk);
        push(model, "R8 stays clear after release");

        // R7: several rows on one column after clear
        write_cell(4'd1, 3'd4, 1'b1);
        write_cell(4'd10, 3'd4, 1'b1);
        write_cell(4'd5, 3'd4, 1'b1);

        repeat (3) @(negedge clk);
        done = 1;
        summary();
    end
endmodule